// File: doc/BRIEF.md
# Programmable Address-Range Chip Select Unit

The unit watches a 16-bit CPU address and drives five active-low chip select lines. Each one covers a range set in 1 KB steps. Each channel keeps a lower and an upper page bound. A page is address bits 15:10. Each channel also keeps a two-bit wait count, and one bit of a shared enable register gates it. A channel claims the address when it is enabled and the page lies inside its inclusive bounds.

Only one line may ever be low. When several enabled channels match, the lowest-numbered one wins. An input flag that marks an on-chip resource hit silences every line. The winning channel's wait count goes to the bus sequencer as the number of extra E-clock cycles to insert. A per-channel flag tells the pin logic which port pins must be driven as outputs, whatever their direction bits say. The decode is combinational from the address and the stored registers. The registers are loaded through a small synchronous write port.

Top module: `cs_range_decoder`

## Requirements
- R1: After reset, all enables are clear, every `cs_n` bit is 1, `stretch` is 0 and `pin_force_out` is 0 for any address.
- R2: A write with `reg_we`=1 at a rising clock edge updates one register, selected by `reg_chan` and `reg_field`. Field 0 writes channel `reg_chan`'s lower page from data[5:0] and its wait count from data[7:6]. Field 1 writes the upper page from data[5:0]. Field 2 writes the enable register from data[4:0], where bit i enables channel i, and ignores `reg_chan`. A write with field 3, or with `reg_chan` of 5 to 7 in fields 0 and 1, changes nothing.
- R3: An enabled channel matches when lower ≤ addr[15:10] ≤ upper. Address bits 9:0 have no effect.
- R4: A channel whose lower page is greater than its upper page never asserts.
- R5: A channel whose enable bit is 0 never asserts.
- R6: When several enabled channels match, only the lowest-numbered one drives its `cs_n` bit low. At most one bit of `cs_n` is ever low.
- R7: While `onchip_hit` is 1, every `cs_n` bit is 1 and `stretch` is 0.
- R8: `stretch` equals the wait count of the channel whose `cs_n` is low, and 0 when none is low.
- R9: `pin_force_out[i]` equals enable bit i, whatever the address or `onchip_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register write port |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_chan | input | 3 | Channel index for fields 0 and 1 |
| reg_field | input | 2 | 0 lower page and wait, 1 upper page, 2 enable |
| reg_wdata | input | 8 | Write data |
| cpu_addr | input | 16 | CPU logical address |
| onchip_hit | input | 1 | An on-chip resource claims the address |
| cs_n | output | 5 | Active-low chip selects, bit i for channel i |
| stretch | output | 2 | Extra E-clock cycles for the current access |
| pin_force_out | output | 5 | Pin i must be driven as an output |

## Verification
Every one of the 64 pages is applied with the low bits all zero, all one and a mixed pattern, each with `onchip_hit` low and high. This separates a page-only compare from one that leaks low bits, and checks suppression on every page. The sweeps run over several register sets, each aimed at one behaviour. Overlapping ranges with distinct wait counts tell a correct priority order from a wrong one and show which channel's count reaches `stretch`. A single-page range and full-span ranges test both inclusive edges. A deliberately inverted range separates a correct magnitude test from a wrapping one. A disabled channel sits over live pages. A set of writes that must be discarded tests the write port's decode.

// File: rtl/cs_range_decoder.sv
module cs_range_decoder #(
  parameter int NCH = 5,
  parameter int AW  = 16,
  parameter int PW  = 6,
  parameter int SW  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [$clog2(NCH)-1:0] reg_chan,
  input  logic [1:0]             reg_field,
  input  logic [((PW+SW) > NCH ? (PW+SW) : NCH)-1:0] reg_wdata,
  input  logic [AW-1:0]          cpu_addr,
  input  logic                   onchip_hit,
  output logic [NCH-1:0]         cs_n,
  output logic [SW-1:0]          stretch,
  output logic [NCH-1:0]         pin_force_out
);
  localparam int CHW = $clog2(NCH);

  logic [PW-1:0]  lo_q  [NCH];
  logic [PW-1:0]  hi_q  [NCH];
  logic [SW-1:0]  wait_q[NCH];
  logic [NCH-1:0] en_q;

  wire [PW-1:0] page = cpu_addr[AW-1 -: PW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        lo_q[i]   <= '1;
        hi_q[i]   <= '0;
        wait_q[i] <= '0;
      end
    end else if (reg_we) begin
      if (reg_field == 2'd2)
        en_q <= reg_wdata[NCH-1:0];
      else if (reg_field == 2'd0 && reg_chan < CHW'(NCH)) begin
        lo_q[reg_chan]   <= reg_wdata[PW-1:0];
        wait_q[reg_chan] <= reg_wdata[PW+SW-1:PW];
      end else if (reg_field == 2'd1 && reg_chan < CHW'(NCH))
        hi_q[reg_chan] <= reg_wdata[PW-1:0];
    end
  end

  logic [NCH-1:0] hit, grant;
  always_comb
    for (int i = 0; i < NCH; i++)
      hit[i] = en_q[i] && (lo_q[i] <= page) && (page <= hi_q[i]);

  assign grant = onchip_hit ? '0 : (hit & (~hit + NCH'(1)));
  assign cs_n = ~grant;
  assign pin_force_out = en_q;

  always_comb begin
    stretch = '0;
    for (int i = 0; i < NCH; i++)
      if (grant[i]) stretch = stretch | wait_q[i];
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (pin_force_out == '0 && cs_n == '1));
  assert_single_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pin_force_out) & (~cs_n)) == '0);
  assert_onchip_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    onchip_hit |-> (cs_n == '1 && stretch == '0));
  assert_idle_no_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == '1) |-> (stretch == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_inv
    assert_inverted_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_q[g] > hi_q[g]) |-> cs_n[g]);
  end
endmodule

// File: tb/test_cs_range_decoder.sv
module test_cs_range_decoder;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_chan = 0;
  logic [1:0] reg_field = 0;
  logic [7:0] reg_wdata = 0;
  logic [15:0] cpu_addr = 0;
  logic onchip_hit = 0;
  logic [4:0] cs_n, pin_force_out;
  logic [1:0] stretch;

  cs_range_decoder i_cs_range_decoder (.*);

  always #2.5 clk = ~clk;

  int vectors = 0, fails = 0;
  bit done = 0;
  logic [5:0] m_lo[5], m_hi[5];
  logic [1:0] m_wt[5];
  logic [4:0] m_en = 0;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: expected completion, got timeout");
    summary();
  end

  task automatic wr(input logic [2:0] ch, input logic [1:0] f, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_chan = ch; reg_field = f; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (f == 2) m_en = d[4:0];
    else if (f == 0 && ch < 5) begin m_lo[ch] = d[5:0]; m_wt[ch] = d[7:6]; end
    else if (f == 1 && ch < 5) m_hi[ch] = d[5:0];
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (addr %h onchip %0b)", tag, act, exp, cpu_addr, onchip_hit);
    end
  endtask

  task automatic sweep(input string tag);
    for (int p = 0; p < 64; p++)
      for (int k = 0; k < 3; k++)
        for (int h = 0; h < 2; h++) begin
          logic [9:0] low;
          logic [4:0] ecs;
          logic [1:0] ew;
          low = (k == 0) ? 10'h000 : (k == 1) ? 10'h3FF : 10'((p * 37 + 101) & 10'h3FF);
          @(negedge clk);
          cpu_addr = {6'(p), low};
          onchip_hit = h[0];
          ecs = 5'b11111; ew = 0;
          if (h == 0)
            for (int i = 0; i < 5; i++)
              if (ecs == 5'b11111 && m_en[i] && m_lo[i] <= 6'(p) && 6'(p) <= m_hi[i]) begin
                ecs[i] = 1'b0; ew = m_wt[i];
              end
          #1;
          chk(h ? "R7 cs_n" : tag, 32'(cs_n), 32'(ecs));
          chk("R8 stretch", 32'(stretch), 32'(ew));
          chk("R9 pin_force_out", 32'(pin_force_out), 32'(m_en));
        end
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin m_lo[i] = 6'h3F; m_hi[i] = 0; m_wt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    sweep("R1 reset idle");

    wr(0, 0, {2'd1, 6'd4});  wr(0, 1, 8'd10);
    wr(1, 0, {2'd2, 6'd8});  wr(1, 1, 8'd20);
    wr(2, 0, {2'd3, 6'd30}); wr(2, 1, 8'd30);
    wr(3, 0, {2'd1, 6'd0});  wr(3, 1, 8'd63);
    wr(4, 0, {2'd3, 6'd50}); wr(4, 1, 8'd63);
    wr(0, 2, 8'b10111);
    sweep("R3 R5 R6 range/priority");

    wr(3, 2, 8'b01000);
    sweep("R2 R3 enable field ignores chan");

    wr(0, 0, {2'd2, 6'd40}); wr(0, 1, 8'd20);
    wr(1, 0, {2'd1, 6'd20}); wr(1, 1, 8'd40);
    wr(0, 2, 8'b11111);
    sweep("R4 R6 inverted range");

    wr(1, 3, 8'hFF); wr(5, 0, 8'h00); wr(6, 1, 8'h3F); wr(7, 0, 8'hC1);
    sweep("R2 ignored writes");

    wr(0, 2, 8'b00000);
    sweep("R5 R9 all disabled");
    summary();
  end
endmodule